// File: doc/BRIEF.md
# Shorts Detect and Isolate Sequencer

This block steers a board tester's switching matrix to locate unwanted low-impedance paths between up to `NUM_NODES` listed nodes. For each node in turn it connects that node alone as the source and ties every node with a higher index on the opposite side. It then asks an external measurement unit for one result. The unit compares the impedance against the threshold that the block presents and returns a single bit: 1 means the impedance is at or below the threshold (a short), and 0 means it is above the threshold (open).

When the grouped measurement reports a short, the sequencer drops the tied nodes one at a time, lowest index first, and measures again after each drop. The node whose removal makes the short vanish is reported as the partner of the current source. The nodes removed before that partner are then grouped again and searched, so a single source can yield several partners. A short that survives the removal of every node is reported as a phantom. Each node can carry its own threshold and its own settling delay, which are written through a configuration port. The settling delay applies to every measurement made while that node is the source. A node with no delay override uses the block's default delay.

Top module: `shorts_seq`

## Requirements
- R1: After reset, and whenever no scan is running, `src_sel`, `tie_mask`, `meas_req`, `rpt_valid`, `done` and `busy` are all 0.
- R2: The first measurement for source node s has `src_sel` equal to one-hot bit s. Its `tie_mask` has bit j set exactly for s < j < scan count.
- R3: Sources are taken in ascending index order from 0 to (scan count - 2). After the last source is finished, `done` pulses for one cycle and `busy` then falls.
- R4: While a node is the source, `meas_thr` carries that node's configured threshold, or `DEF_THR` if the node has never been written. A `meas_short` value of 1 marks a short and 0 marks open.
- R5: `meas_req` rises exactly d+1 cycles after `src_sel`/`tie_mask` take a new value. Here d is the source node's delay when its override bit is 1, and `DEF_DLY` otherwise. Writing the override bit as 0 restores the default.
- R6: After a short is measured, the next measurement has the lowest-index tied node removed from `tie_mask` and nothing else changed. Removal continues until the group is empty.
- R7: If a measurement taken after removing node k returns open, a one-cycle report is issued with `rpt_src` = source, `rpt_dst` = k and `rpt_phantom` = 0.
- R8: After a report, the nodes removed before k in that round are tied again and measured as a new group. Further partners of the same source are therefore reported in descending index order.
- R9: If the measurement with an empty group still returns short, a report is issued with `rpt_phantom` = 1 and `rpt_dst` = `rpt_src`. The scan then moves to the next source.
- R10: `meas_req` stays high until a cycle with `meas_done` = 1 and is low in the following cycle. A `meas_done` pulse that arrives while `meas_req` is low has no effect on timing or results.
- R11: A `start` with `node_cnt` below 2 produces a `done` pulse and no measurement. A `node_cnt` above `NUM_NODES` is treated as `NUM_NODES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan; ignored while busy |
| node_cnt | input | CNT_W | Number of listed nodes for the scan |
| cfg_we | input | 1 | Write strobe for per-node settings |
| cfg_idx | input | IDX_W | Node written |
| cfg_thr | input | THR_W | Threshold for that node |
| cfg_dly | input | DLY_W | Settling delay in cycles for that node |
| cfg_dly_ovr | input | 1 | 1: use cfg_dly, 0: use default delay |
| src_sel | output | NUM_NODES | One-hot source node select |
| tie_mask | output | NUM_NODES | Nodes tied on the detector side |
| meas_req | output | 1 | Measurement request, held until done |
| meas_thr | output | THR_W | Active threshold for the measurement |
| meas_done | input | 1 | Measurement complete strobe |
| meas_short | input | 1 | 1 = impedance at or below threshold |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_src | output | IDX_W | Source node of the report |
| rpt_dst | output | IDX_W | Partner node, or source for a phantom |
| rpt_phantom | output | 1 | Report is a phantom short |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan end |

## Verification
The hardest case is a source with two partners. A design that stopped after the first partner, or that failed to re-tie the nodes removed earlier, would report only the higher partner. A phantom source is used to check that an empty group which still measures short gives a flagged report naming the source itself, rather than a bogus partner or a hang. The settle-delay checks count cycles from each new switch pattern, so an off-by-one counter or a delay taken from the wrong node shows up as a wrong latency. A stray `meas_done` injected during settling would shorten the delay or inject a result in a design that does not gate the handshake. Scan counts of 0, 1 and above `NUM_NODES` catch designs that measure with no partners or index past the list.

// File: rtl/shorts_seq_pkg.sv
package shorts_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_MEAS,
      ST_EVAL,
      ST_DONE
   } seq_state_t;

   typedef enum logic {
      PH_DETECT,
      PH_ISOLATE
   } seq_phase_t;

endpackage

// File: rtl/shorts_cfg_table.sv
module shorts_cfg_table #(
   parameter int NODES   = 32,
   parameter int IDX_W   = 5,
   parameter int THR_W   = 16,
   parameter int DLY_W   = 16,
   parameter int DEF_THR = 10,
   parameter int DEF_DLY = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [THR_W-1:0] wr_thr,
   input  logic [DLY_W-1:0] wr_dly,
   input  logic             wr_ovr,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [THR_W-1:0] ra_thr,
   output logic [DLY_W-1:0] ra_dly,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [DLY_W-1:0] rb_dly
);

   logic [THR_W-1:0] thr_all [NODES];
   logic [DLY_W-1:0] dly_all [NODES];

   for (genvar g = 0; g < NODES; g++) begin : g_entry
      logic [THR_W-1:0] thr_r;
      logic [DLY_W-1:0] dly_r;
      logic             ovr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_r <= THR_W'(DEF_THR);
            dly_r <= '0;
            ovr_r <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            thr_r <= wr_thr;
            dly_r <= wr_dly;
            ovr_r <= wr_ovr;
         end
      end

      assign thr_all[g] = thr_r;
      assign dly_all[g] = ovr_r ? dly_r : DLY_W'(DEF_DLY);
   end

   assign ra_thr = (32'(ra_idx) < NODES) ? thr_all[ra_idx] : THR_W'(DEF_THR);
   assign ra_dly = (32'(ra_idx) < NODES) ? dly_all[ra_idx] : DLY_W'(DEF_DLY);
   assign rb_dly = (32'(rb_idx) < NODES) ? dly_all[rb_idx] : DLY_W'(DEF_DLY);

endmodule

// File: rtl/shorts_grp_mask.sv
module shorts_grp_mask #(
   parameter int NODES = 32,
   parameter int IDX_W = 5,
   parameter int CNT_W = 6
)(
   input  logic [IDX_W-1:0] src,
   input  logic [CNT_W-1:0] cnt,
   output logic [NODES-1:0] mask
);

   for (genvar g = 0; g < NODES; g++) begin : g_bit
      assign mask[g] = (IDX_W'(g) > src) && (CNT_W'(g) < cnt);
   end

endmodule

// File: rtl/shorts_low_pick.sv
module shorts_low_pick #(
   parameter int NODES = 32,
   parameter int IDX_W = 5
)(
   input  logic [NODES-1:0] vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = NODES - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/shorts_settle_timer.sv
module shorts_settle_timer #(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/shorts_seq.sv
module shorts_seq
   import shorts_seq_pkg::*;
#(
   parameter int NUM_NODES = 32,
   parameter int THR_W     = 16,
   parameter int DLY_W     = 16,
   parameter int DEF_THR   = 10,
   parameter int DEF_DLY   = 8,
   localparam int IDX_W    = $clog2(NUM_NODES),
   localparam int CNT_W    = $clog2(NUM_NODES + 1)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CNT_W-1:0]     node_cnt,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [THR_W-1:0]     cfg_thr,
   input  logic [DLY_W-1:0]     cfg_dly,
   input  logic                 cfg_dly_ovr,
   output logic [NUM_NODES-1:0] src_sel,
   output logic [NUM_NODES-1:0] tie_mask,
   output logic                 meas_req,
   output logic [THR_W-1:0]     meas_thr,
   input  logic                 meas_done,
   input  logic                 meas_short,
   output logic                 rpt_valid,
   output logic [IDX_W-1:0]     rpt_src,
   output logic [IDX_W-1:0]     rpt_dst,
   output logic                 rpt_phantom,
   output logic                 busy,
   output logic                 done
);

   if (NUM_NODES < 2) begin : g_bad_nodes
      $error("shorts_seq: NUM_NODES must be at least 2");
   end
   if ((DLY_W < 1) || (DLY_W > 31)) begin : g_bad_dly_w
      $error("shorts_seq: DLY_W must be 1..31");
   end
   if ((THR_W < 1) || (THR_W > 31)) begin : g_bad_thr_w
      $error("shorts_seq: THR_W must be 1..31");
   end
   if ((DEF_DLY < 0) || (DEF_DLY >= (1 << DLY_W))) begin : g_bad_def_dly
      $error("shorts_seq: DEF_DLY does not fit DLY_W");
   end
   if ((DEF_THR < 0) || (DEF_THR >= (1 << THR_W))) begin : g_bad_def_thr
      $error("shorts_seq: DEF_THR does not fit THR_W");
   end

   localparam logic [NUM_NODES-1:0] ONE = {{(NUM_NODES-1){1'b0}}, 1'b1};

   seq_state_t            state_q;
   seq_phase_t            phase_q;
   logic [IDX_W-1:0]      src_q, iso_q, nsrc, low_idx, rb_idx;
   logic [CNT_W-1:0]      cnt_q, cnt_in;
   logic [NUM_NODES-1:0]  cand_q, tie_q, start_mask, adv_mask, ncand;
   logic                  short_q, low_any, last_src;
   logic                  rpt_v_q, rpt_ph_q;
   logic [IDX_W-1:0]      rpt_s_q, rpt_d_q;
   logic [THR_W-1:0]      ra_thr;
   logic [DLY_W-1:0]      ra_dly, rb_dly, tmr_val;
   logic                  tmr_load, tmr_dec, tmr_zero;
   logic                  begin_scan, act_adv, act_rem, act_redet, act_found, act_phantom;

   assign nsrc     = src_q + IDX_W'(1);
   assign cnt_in   = (node_cnt > CNT_W'(NUM_NODES)) ? CNT_W'(NUM_NODES) : node_cnt;
   assign last_src = (CNT_W'(src_q) + CNT_W'(2)) >= cnt_q;
   assign ncand    = cand_q & ~tie_q & ~(ONE << iso_q);
   assign rb_idx   = (state_q == ST_IDLE) ? '0 : nsrc;

   shorts_cfg_table #(
      .NODES(NUM_NODES), .IDX_W(IDX_W), .THR_W(THR_W), .DLY_W(DLY_W),
      .DEF_THR(DEF_THR), .DEF_DLY(DEF_DLY)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_thr(cfg_thr), .wr_dly(cfg_dly), .wr_ovr(cfg_dly_ovr),
      .ra_idx(src_q), .ra_thr(ra_thr), .ra_dly(ra_dly),
      .rb_idx(rb_idx), .rb_dly(rb_dly)
   );

   shorts_grp_mask #(.NODES(NUM_NODES), .IDX_W(IDX_W), .CNT_W(CNT_W)) start_mask_i (
      .src('0), .cnt(cnt_in), .mask(start_mask)
   );

   shorts_grp_mask #(.NODES(NUM_NODES), .IDX_W(IDX_W), .CNT_W(CNT_W)) adv_mask_i (
      .src(nsrc), .cnt(cnt_q), .mask(adv_mask)
   );

   shorts_low_pick #(.NODES(NUM_NODES), .IDX_W(IDX_W)) pick_i (
      .vec(tie_q), .idx(low_idx), .any(low_any)
   );

   shorts_settle_timer #(.W(DLY_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .dec(tmr_dec), .zero(tmr_zero)
   );

   always_comb begin
      act_adv     = 1'b0;
      act_rem     = 1'b0;
      act_redet   = 1'b0;
      act_found   = 1'b0;
      act_phantom = 1'b0;
      if (state_q == ST_EVAL) begin
         if (phase_q == PH_DETECT) begin
            if (short_q) act_rem = 1'b1;
            else         act_adv = 1'b1;
         end else if (short_q) begin
            if (low_any) act_rem = 1'b1;
            else begin
               act_phantom = 1'b1;
               act_adv     = 1'b1;
            end
         end else begin
            act_found = 1'b1;
            if (ncand == '0) act_adv   = 1'b1;
            else             act_redet = 1'b1;
         end
      end
      begin_scan = (state_q == ST_IDLE) && start && (cnt_in >= CNT_W'(2));
      tmr_load   = begin_scan || (act_adv && !last_src) || act_rem || act_redet;
      tmr_val    = (begin_scan || act_adv) ? rb_dly : ra_dly;
      tmr_dec    = (state_q == ST_SETTLE) && !tmr_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         phase_q  <= PH_DETECT;
         src_q    <= '0;
         iso_q    <= '0;
         cnt_q    <= '0;
         cand_q   <= '0;
         tie_q    <= '0;
         short_q  <= 1'b0;
         rpt_v_q  <= 1'b0;
         rpt_ph_q <= 1'b0;
         rpt_s_q  <= '0;
         rpt_d_q  <= '0;
      end else begin
         rpt_v_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (cnt_in < CNT_W'(2)) begin
                     state_q <= ST_DONE;
                  end else begin
                     src_q   <= '0;
                     cnt_q   <= cnt_in;
                     cand_q  <= start_mask;
                     tie_q   <= start_mask;
                     phase_q <= PH_DETECT;
                     state_q <= ST_SETTLE;
                  end
               end
            end
            ST_SETTLE: begin
               if (tmr_zero) state_q <= ST_MEAS;
            end
            ST_MEAS: begin
               if (meas_done) begin
                  short_q <= meas_short;
                  state_q <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (act_found || act_phantom) begin
                  rpt_v_q  <= 1'b1;
                  rpt_s_q  <= src_q;
                  rpt_d_q  <= act_phantom ? src_q : iso_q;
                  rpt_ph_q <= act_phantom;
               end
               if (act_rem) begin
                  tie_q   <= tie_q & ~(ONE << low_idx);
                  iso_q   <= low_idx;
                  phase_q <= PH_ISOLATE;
                  state_q <= ST_SETTLE;
               end else if (act_redet) begin
                  cand_q  <= ncand;
                  tie_q   <= ncand;
                  phase_q <= PH_DETECT;
                  state_q <= ST_SETTLE;
               end else if (act_adv) begin
                  if (last_src) begin
                     cand_q  <= '0;
                     tie_q   <= '0;
                     state_q <= ST_DONE;
                  end else begin
                     src_q   <= nsrc;
                     cand_q  <= adv_mask;
                     tie_q   <= adv_mask;
                     phase_q <= PH_DETECT;
                     state_q <= ST_SETTLE;
                  end
               end
            end
            ST_DONE: begin
               src_q   <= '0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);
   assign meas_req    = (state_q == ST_MEAS);
   assign src_sel     = ((state_q == ST_SETTLE) || (state_q == ST_MEAS) || (state_q == ST_EVAL))
                        ? (ONE << src_q) : '0;
   assign tie_mask    = tie_q;
   assign meas_thr    = ra_thr;
   assign rpt_valid   = rpt_v_q;
   assign rpt_src     = rpt_s_q;
   assign rpt_dst     = rpt_d_q;
   assign rpt_phantom = rpt_ph_q;

endmodule

// File: rtl/shorts_seq_chk.sv
module shorts_seq_chk #(
   parameter int NUM_NODES = 32,
   parameter int IDX_W     = 5
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_NODES-1:0] src_sel,
   input logic [NUM_NODES-1:0] tie_mask,
   input logic                 meas_req,
   input logic                 meas_done,
   input logic                 rpt_valid,
   input logic [IDX_W-1:0]     rpt_src,
   input logic [IDX_W-1:0]     rpt_dst,
   input logic                 rpt_phantom,
   input logic                 busy,
   input logic                 done
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!meas_req && (src_sel == '0) && (tie_mask == '0) && !rpt_valid)); // R1
   AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      meas_req |-> ($countones(src_sel) == 1)); // R2
   AST_SRC_NOT_TIED: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel & tie_mask) == '0); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_req && !meas_done) |=> meas_req); // R10
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_req && meas_done) |=> !meas_req); // R10
   AST_REQ_STABLE_SW: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_req && $past(meas_req)) |-> ($stable(tie_mask) && $stable(src_sel))); // R5
   AST_RPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> !rpt_valid); // R7
   AST_RPT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && !rpt_phantom) |-> (rpt_dst > rpt_src)); // R7
   AST_PHANTOM_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && rpt_phantom) |-> (rpt_dst == rpt_src)); // R9

endmodule

bind shorts_seq shorts_seq_chk #(.NUM_NODES(NUM_NODES), .IDX_W(IDX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .tie_mask(tie_mask),
   .meas_req(meas_req), .meas_done(meas_done), .rpt_valid(rpt_valid),
   .rpt_src(rpt_src), .rpt_dst(rpt_dst), .rpt_phantom(rpt_phantom),
   .busy(busy), .done(done)
);

// File: tb/shorts_seq_tb_top.sv
module shorts_seq_tb_top;

   localparam int N  = 8;
   localparam int IW = $clog2(N);
   localparam int CW = $clog2(N + 1);
   localparam int TW = 16;
   localparam int DW = 16;
   localparam int DT = 10;
   localparam int DD = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] node_cnt = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [TW-1:0] cfg_thr = '0;
   logic [DW-1:0] cfg_dly = '0;
   logic          cfg_dly_ovr = 1'b0;
   logic [N-1:0]  src_sel, tie_mask;
   logic          meas_req;
   logic [TW-1:0] meas_thr;
   logic          meas_done = 1'b0;
   logic          meas_short = 1'b0;
   logic          rpt_valid, rpt_phantom, busy, done;
   logic [IW-1:0] rpt_src, rpt_dst;

   always #4 clk = ~clk;

   shorts_seq #(.NUM_NODES(N), .THR_W(TW), .DLY_W(DW), .DEF_THR(DT), .DEF_DLY(DD)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .node_cnt(node_cnt),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_thr(cfg_thr), .cfg_dly(cfg_dly),
      .cfg_dly_ovr(cfg_dly_ovr), .src_sel(src_sel), .tie_mask(tie_mask),
      .meas_req(meas_req), .meas_thr(meas_thr), .meas_done(meas_done),
      .meas_short(meas_short), .rpt_valid(rpt_valid), .rpt_src(rpt_src),
      .rpt_dst(rpt_dst), .rpt_phantom(rpt_phantom), .busy(busy), .done(done)
   );

   int checks = 0;
   int errors = 0;
   bit finished_all = 1'b0;

   logic [N-1:0] pm [N];
   int ph_src = -1;

   int m_n, r_n, done_n, t_cnt;
   logic [N-1:0] m_src [64];
   logic [N-1:0] m_tie [64];
   int m_t [64];
   int m_thr [64];
   int r_src [16];
   int r_dst [16];
   int r_ph [16];
   logic [2*N-1:0] prev_pat = '0;
   logic req_prev = 1'b0;

   always @(negedge clk) begin
      if ({src_sel, tie_mask} != prev_pat) t_cnt = 0;
      else t_cnt = t_cnt + 1;
      prev_pat = {src_sel, tie_mask};
      if (meas_req && !req_prev && m_n < 64) begin
         m_src[m_n] = src_sel;
         m_tie[m_n] = tie_mask;
         m_t[m_n]   = t_cnt;
         m_thr[m_n] = int'(meas_thr);
         m_n = m_n + 1;
      end
      req_prev = meas_req;
      if (rpt_valid && r_n < 16) begin
         r_src[r_n] = int'(rpt_src);
         r_dst[r_n] = int'(rpt_dst);
         r_ph[r_n]  = int'(rpt_phantom);
         r_n = r_n + 1;
      end
      if (done) done_n = done_n + 1;
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_logs();
      m_n = 0;
      r_n = 0;
      done_n = 0;
   endtask

   task automatic clear_pairs();
      for (int i = 0; i < N; i++) pm[i] = '0;
      ph_src = -1;
   endtask

   task automatic add_pair(input int a, input int b);
      pm[a][b] = 1'b1;
      pm[b][a] = 1'b1;
   endtask

   function automatic bit model_short();
      int s = -1;
      for (int i = 0; i < N; i++) if (src_sel[i]) s = i;
      if (s < 0) return 1'b0;
      if (s == ph_src) return 1'b1;
      for (int j = 0; j < N; j++) if (tie_mask[j] && pm[s][j]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic cfg_write(input int idx, input int thr, input int dly, input bit ovr);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_idx = IW'(idx);
      cfg_thr = TW'(thr);
      cfg_dly = DW'(dly);
      cfg_dly_ovr = ovr;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_scan(input int cnt, input int spurious_at);
      int cyc = 0;
      bit fin = 1'b0;
      clear_logs();
      @(negedge clk);
      node_cnt = CW'(cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!fin && cyc < 5000) begin
         if (done) begin
            fin = 1'b1;
         end else if (meas_req) begin
            repeat (2) @(negedge clk);
            meas_short = model_short();
            meas_done = 1'b1;
            @(negedge clk);
            meas_done = 1'b0;
            meas_short = 1'b0;
         end else if (cyc == spurious_at) begin
            meas_done = 1'b1;
            meas_short = 1'b1;
            @(negedge clk);
            meas_done = 1'b0;
            meas_short = 1'b0;
         end else begin
            @(negedge clk);
         end
         cyc++;
      end
      chk("R3 scan completes", fin, 1);
      repeat (2) @(negedge clk);
      chk("R3 busy low after scan", busy, 0);
   endtask

   task automatic t_reset();
      chk("R1 src_sel at reset", src_sel, 0);
      chk("R1 tie_mask at reset", tie_mask, 0);
      chk("R1 meas_req at reset", meas_req, 0);
      chk("R1 rpt_valid at reset", rpt_valid, 0);
      chk("R1 busy/done at reset", {busy, done}, 0);
   endtask

   task automatic t_no_shorts();
      clear_pairs();
      run_scan(4, -1);
      chk("R2 measurement count", m_n, 3);
      for (int k = 0; k < 3; k++) begin
         chk("R2 source select", m_src[k], 1 << k);
         chk("R2 tied group", m_tie[k], (8'h0F >> (k + 1)) << (k + 1));
      end
      chk("R4 default threshold", m_thr[0], DT);
      chk("R5 default settle", m_t[0], DD + 1);
      chk("R3 no report when open", r_n, 0);
      chk("R3 single done pulse", done_n, 1);
      chk("R1 idle after scan", {src_sel, tie_mask}, 0);
   endtask

   task automatic t_single_short();
      clear_pairs();
      add_pair(1, 3);
      run_scan(5, -1);
      chk("R6 measurement count", m_n, 7);
      chk("R2 detect group src1", m_tie[1], 8'h1C);
      chk("R6 remove node2", m_tie[2], 8'h18);
      chk("R6 remove node3", m_tie[3], 8'h10);
      chk("R8 regroup earlier node", m_tie[4], 8'h04);
      chk("R7 report count", r_n, 1);
      chk("R7 report pair", {r_src[0], r_dst[0], r_ph[0]}, {32'd1, 32'd3, 32'd0});
   endtask

   task automatic t_multi_partner();
      clear_pairs();
      add_pair(0, 2);
      add_pair(0, 4);
      run_scan(5, -1);
      chk("R8 measurement count", m_n, 12);
      chk("R6 empty group measured", m_tie[4], 8'h00);
      chk("R8 regroup after first partner", m_tie[5], 8'h0E);
      chk("R8 report count", r_n, 2);
      chk("R8 higher partner first", {r_src[0], r_dst[0], r_ph[0]}, {32'd0, 32'd4, 32'd0});
      chk("R8 lower partner second", {r_src[1], r_dst[1], r_ph[1]}, {32'd0, 32'd2, 32'd0});
   endtask

   task automatic t_phantom();
      clear_pairs();
      ph_src = 1;
      run_scan(3, -1);
      chk("R9 measurement count", m_n, 3);
      chk("R9 empty group last", m_tie[2], 8'h00);
      chk("R9 report count", r_n, 1);
      chk("R9 phantom report", {r_src[0], r_dst[0], r_ph[0]}, {32'd1, 32'd1, 32'd1});
      chk("R9 done after phantom", done_n, 1);
   endtask

   task automatic t_config();
      clear_pairs();
      cfg_write(1, 16'h55, 7, 1'b1);
      cfg_write(2, DT, 0, 1'b1);
      run_scan(4, -1);
      chk("R5 default delay src0", m_t[0], DD + 1);
      chk("R5 override delay src1", m_t[1], 8);
      chk("R5 zero delay src2", m_t[2], 1);
      chk("R4 threshold src0", m_thr[0], DT);
      chk("R4 threshold src1", m_thr[1], 16'h55);
      chk("R4 threshold src2", m_thr[2], DT);
      cfg_write(1, 16'h55, 99, 1'b0);
      run_scan(3, -1);
      chk("R5 override cleared", m_t[1], DD + 1);
      chk("R4 threshold kept", m_thr[1], 16'h55);
   endtask

   task automatic t_counts();
      clear_pairs();
      run_scan(1, -1);
      chk("R11 count 1 no measure", m_n, 0);
      chk("R11 count 1 done", done_n, 1);
      run_scan(0, -1);
      chk("R11 count 0 no measure", m_n, 0);
      chk("R11 count 0 done", done_n, 1);
      run_scan(12, -1);
      chk("R11 clamped measure count", m_n, N - 1);
      chk("R11 clamped first group", m_tie[0], 8'hFE);
      chk("R11 clamped last group", m_tie[N-2], 8'h80);
   endtask

   task automatic t_spurious();
      clear_pairs();
      cfg_write(0, DT, 10, 1'b1);
      run_scan(2, 3);
      chk("R10 measurement count", m_n, 1);
      chk("R10 settle not cut short", m_t[0], 11);
      chk("R10 stray done no report", r_n, 0);
      chk("R10 done once", done_n, 1);
   endtask

   initial begin
      clear_logs();
      clear_pairs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_shorts();
      t_single_short();
      t_multi_partner();
      t_phantom();
      t_config();
      t_counts();
      t_spurious();
      finished_all = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished_all) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule